// File: doc/BRIEF.md
# Low-Power Interrupt Capture Controller

This block watches a wide vector of interrupt lines while the main interrupt controller is powered down and holds on to every event it sees. Each line has its own mask, sensitivity (edge or level) and polarity. When the main controller is powered up again, downstream logic reads the held events from a pending vector and replays them.

Software reaches the block through a simple 32-bit register port: a write strobe, a byte address and write data, with a combinational read path. Per-line settings are packed 32 lines to a word. Mask, sensitivity and polarity each have a read view and separate write-one-to-set and write-one-to-clear aliases. Latched events are cleared through an acknowledge bank. A single control word holds the enable, an edge-only override, a flush request and a self-clearing software reset. Each input passes through a two-flop synchronizer before detection.

Top module: `lpcap_ctrl`

## Requirements
- R1: Line n sits at word n/32, bit n%32 of every bank (14 words for 439 lines). Bits above line 438 in word 13 read as zero and ignore writes. A word index beyond 13 reads as zero.
- R2: The bank address is byte address bits [11:7] and the word index is bits [6:2]. The bank codes are: 0 status, 1 acknowledge, 2 mask, 3 mask-set, 4 mask-clear, 5 sensitivity, 6 sensitivity-set, 7 sensitivity-clear, 8 polarity, 9 polarity-set, 10 polarity-clear, 12 control. The status, mask, sensitivity, polarity and control banks read back their current bits. The pending output equals the status bits.
- R3: A write to a set or clear alias changes only the bit positions written as 1. Bits written as 0 keep their value.
- R4: Writing 1 to an acknowledge bit clears the matching status bit, unless the line's capture condition holds in that same cycle.
- R5: A line whose mask bit is 1 never gains a new status bit. A mask bit of 0 allows capture.
- R6: In edge mode (sensitivity 0), polarity 1 captures a rising edge and polarity 0 captures a falling edge of the synchronized input. The edge opposite to the selected one captures nothing.
- R7: In level mode (sensitivity 1), a line is captured in every cycle its synchronized input equals its polarity bit. An acknowledge given while the level persists therefore leaves the status set.
- R8: Control bit 1 (edge-only) makes every line use edge capture, whatever its sensitivity bit.
- R9: While control bit 0 (enable) is 0, no status bit is set.
- R10: A status bit stays set until it is acknowledged or cleared by a reset.
- R11: Writing control bit 2 (flush) sets the flush bit for exactly one cycle. During that cycle the flush_pulse output is high, and afterwards the bit clears itself.
- R12: Writing control bit 20 starts a software reset one cycle later. It clears all status bits and control bits [2:0], sets every mask bit to 1, and leaves sensitivity and polarity unchanged.
- R13: After hardware reset, every mask bit is 1, every polarity bit is 1, every sensitivity bit is 0, and the status bits and control word are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Raw interrupt lines, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pend_out | output | NUM_LINES | Latched event per line |
| flush_pulse | output | 1 | One-cycle flush indication |

## Verification
The bound checker watches four things on every cycle, across the whole pending vector:
- no status bit appears while capture is disabled or the line is masked;
- status bits are kept unless an acknowledge or software reset is applied;
- the software reset leaves the state it promises;
- a lone flush request gives a single-cycle pulse.

The choice of edge against level capture, the polarity selection, the edge-only override, the set/clear alias semantics and the handling of the last partial word depend on particular input waveforms and register sequences. Only the bench scenarios exercise those, by reading the banks back at the ports.

// File: rtl/lpcap_pkg.sv
package lpcap_pkg;

  // Register bank selected by byte address bits [11:7]
  typedef enum logic [4:0] {
    BK_STAT = 5'd0,
    BK_ACK  = 5'd1,
    BK_MASK = 5'd2,
    BK_MSET = 5'd3,
    BK_MCLR = 5'd4,
    BK_SENS = 5'd5,
    BK_SSET = 5'd6,
    BK_SCLR = 5'd7,
    BK_POL  = 5'd8,
    BK_PSET = 5'd9,
    BK_PCLR = 5'd10,
    BK_CTRL = 5'd12
  } bank_e;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_EO_BIT    = 1;
  localparam int CTRL_FLUSH_BIT = 2;
  localparam int CTRL_SWRST_BIT = 20;

  function automatic int words_for(input int lines);
    return (lines + 31) / 32;
  endfunction

  function automatic int word_of(input int line);
    return line / 32;
  endfunction

  function automatic int bit_of(input int line);
    return line % 32;
  endfunction

endpackage

// File: rtl/lpcap_sync.sv
module lpcap_sync #(
  parameter int N = 439
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/lpcap_cfg_bank.sv
module lpcap_cfg_bank #(
  parameter int   N       = 439,
  parameter logic RST_BIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic         force_all,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= {N{RST_BIT}};
    else if (force_all) q <= {N{RST_BIT}};
    else                q <= (q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/lpcap_line_capture.sv
module lpcap_line_capture #(
  parameter int N = 439
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_in,
  input  logic         en,
  input  logic         edge_only,
  input  logic [N-1:0] mask_vec,
  input  logic [N-1:0] sens_vec,
  input  logic [N-1:0] pol_vec,
  input  logic [N-1:0] ack_vec,
  input  logic         clear_all,
  output logic [N-1:0] pend,
  output logic [N-1:0] hit
);
  logic [N-1:0] synced;
  logic [N-1:0] prev;
  logic [N-1:0] rise_ev;
  logic [N-1:0] fall_ev;
  logic [N-1:0] edge_ev;
  logic [N-1:0] level_ev;
  logic [N-1:0] use_level;

  lpcap_sync #(.N(N)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw_in),
    .dout (synced)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= synced;
  end

  always_comb begin
    rise_ev   = synced & ~prev;
    fall_ev   = ~synced & prev;
    edge_ev   = (rise_ev & pol_vec) | (fall_ev & ~pol_vec);
    level_ev  = ~(synced ^ pol_vec);
    use_level = sens_vec & {N{~edge_only}};
    hit       = {N{en}} & ~mask_vec &
                ((use_level & level_ev) | (~use_level & edge_ev));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend <= '0;
    else if (clear_all) pend <= '0;
    else                pend <= (pend & ~ack_vec) | hit;
  end
endmodule

// File: rtl/lpcap_ctrl.sv
module lpcap_ctrl
  import lpcap_pkg::*;
#(
  parameter int NUM_LINES = 439
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 bus_wr,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_LINES-1:0] pend_out,
  output logic                 flush_pulse
);
  localparam int WORDS  = words_for(NUM_LINES);
  localparam int PAD_W  = WORDS * 32;
  localparam int WIDX_W = 5;

  bank_e              bank_sel;
  logic [WIDX_W-1:0]  word_sel;
  logic [NUM_LINES-1:0] line_wbit;
  logic [NUM_LINES-1:0] ack_vec;
  logic [NUM_LINES-1:0] mask_vec, sens_vec, pol_vec;
  logic [NUM_LINES-1:0] hit_vec;
  logic cfg_en, cfg_edge_only, flush_q, sw_clear;
  logic ctrl_wr, ctrl_flush_wr;
  logic unused_addr;

  assign bank_sel    = bank_e'(bus_addr[11:7]);
  assign word_sel    = bus_addr[6:2];
  assign unused_addr = ^bus_addr[1:0];

  // Data bit of the written word that lands on each line
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_wbit
    assign line_wbit[i] = (word_sel == WIDX_W'(word_of(i))) &&
                          bus_wdata[bit_of(i)];
  end

  function automatic logic [NUM_LINES-1:0] bank_hit(input bank_e b);
    return {NUM_LINES{bus_wr && (bank_sel == b)}} & line_wbit;
  endfunction

  assign ack_vec       = bank_hit(BK_ACK);
  assign ctrl_wr       = bus_wr && (bank_sel == BK_CTRL) && (word_sel == '0);
  assign ctrl_flush_wr = ctrl_wr && bus_wdata[CTRL_FLUSH_BIT];

  lpcap_cfg_bank #(.N(NUM_LINES), .RST_BIT(1'b1)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .set_vec(bank_hit(BK_MSET)), .clr_vec(bank_hit(BK_MCLR)),
    .force_all(sw_clear), .q(mask_vec)
  );

  lpcap_cfg_bank #(.N(NUM_LINES), .RST_BIT(1'b0)) u_sens (
    .clk(clk), .rst_n(rst_n),
    .set_vec(bank_hit(BK_SSET)), .clr_vec(bank_hit(BK_SCLR)),
    .force_all(1'b0), .q(sens_vec)
  );

  lpcap_cfg_bank #(.N(NUM_LINES), .RST_BIT(1'b1)) u_pol (
    .clk(clk), .rst_n(rst_n),
    .set_vec(bank_hit(BK_PSET)), .clr_vec(bank_hit(BK_PCLR)),
    .force_all(1'b0), .q(pol_vec)
  );

  lpcap_line_capture #(.N(NUM_LINES)) u_cap (
    .clk(clk), .rst_n(rst_n), .raw_in(irq_in),
    .en(cfg_en), .edge_only(cfg_edge_only),
    .mask_vec(mask_vec), .sens_vec(sens_vec), .pol_vec(pol_vec),
    .ack_vec(ack_vec), .clear_all(sw_clear),
    .pend(pend_out), .hit(hit_vec)
  );

  // Control word: enable and edge-only persist; flush and reset self-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en <= 1'b0; cfg_edge_only <= 1'b0; flush_q <= 1'b0; sw_clear <= 1'b0;
    end else if (sw_clear) begin
      cfg_en <= 1'b0; cfg_edge_only <= 1'b0; flush_q <= 1'b0; sw_clear <= 1'b0;
    end else if (ctrl_wr) begin
      cfg_en        <= bus_wdata[CTRL_EN_BIT];
      cfg_edge_only <= bus_wdata[CTRL_EO_BIT];
      flush_q       <= bus_wdata[CTRL_FLUSH_BIT];
      sw_clear      <= bus_wdata[CTRL_SWRST_BIT];
    end else begin
      flush_q  <= 1'b0;
      sw_clear <= 1'b0;
    end
  end

  assign flush_pulse = flush_q;

  // Read path
  logic [PAD_W-1:0] pad_view;
  always_comb begin
    pad_view = '0;
    unique case (bank_sel)
      BK_STAT: pad_view[NUM_LINES-1:0] = pend_out;
      BK_MASK: pad_view[NUM_LINES-1:0] = mask_vec;
      BK_SENS: pad_view[NUM_LINES-1:0] = sens_vec;
      BK_POL:  pad_view[NUM_LINES-1:0] = pol_vec;
      default: pad_view = '0;
    endcase
  end

  always_comb begin
    bus_rdata = '0;
    if (bank_sel == BK_CTRL) begin
      if (word_sel == '0) begin
        bus_rdata[CTRL_EN_BIT]    = cfg_en;
        bus_rdata[CTRL_EO_BIT]    = cfg_edge_only;
        bus_rdata[CTRL_FLUSH_BIT] = flush_q;
        bus_rdata[CTRL_SWRST_BIT] = sw_clear;
      end
    end else if (int'(word_sel) < WORDS) begin
      bus_rdata = pad_view[int'(word_sel)*32 +: 32];
    end
  end
endmodule

// File: rtl/lpcap_ctrl_chk.sv
module lpcap_ctrl_chk #(
  parameter int N = 439
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] pend,
  input logic [N-1:0] ack_vec,
  input logic [N-1:0] mask_vec,
  input logic         cfg_en,
  input logic         cfg_edge_only,
  input logic         sw_clear,
  input logic         flush_pulse,
  input logic         ctrl_flush_wr
);
  assert_no_capture_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> ((pend & ~$past(pend)) == '0));

  assert_masked_line_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & $past(mask_vec)) == '0));

  assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_clear && (ack_vec == '0)) |=> ((pend & $past(pend)) == $past(pend)));

  assert_swreset_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear |=> ((pend == '0) && (&mask_vec) && !cfg_en && !cfg_edge_only));

  assert_flush_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_pulse && !ctrl_flush_wr) |=> !flush_pulse);
endmodule

bind lpcap_ctrl lpcap_ctrl_chk #(.N(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend(pend_out), .ack_vec(ack_vec),
  .mask_vec(mask_vec), .cfg_en(cfg_en), .cfg_edge_only(cfg_edge_only),
  .sw_clear(sw_clear), .flush_pulse(flush_pulse), .ctrl_flush_wr(ctrl_flush_wr)
);

// File: tb/lpcap_ctrl_test.sv
module lpcap_ctrl_test;
  localparam int NL = 439;
  localparam logic [4:0] B_STAT = 5'd0, B_ACK = 5'd1, B_MASK = 5'd2,
    B_MSET = 5'd3, B_MCLR = 5'd4, B_SENS = 5'd5, B_SSET = 5'd6, B_SCLR = 5'd7,
    B_POL = 5'd8, B_PCLR = 5'd10, B_CTRL = 5'd12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NL-1:0] irq_in = '0;
  logic bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NL-1:0] pend_out;
  logic flush_pulse;

  always #4 clk = ~clk;

  lpcap_ctrl #(.NUM_LINES(NL)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend_out(pend_out), .flush_pulse(flush_pulse)
  );

  typedef struct {
    int          kind;   // 0 read data, 1 pending bit, 2 flush output
    int          idx;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  event  mon_ev;
  int    n_chk = 0, n_bad = 0;
  bit    done = 1'b0;

  // Monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(mon_ev);
      #1;
      while (exp_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = exp_q.pop_front();
        case (it.kind)
          0: act = bus_rdata;
          1: act = {31'd0, pend_out[it.idx]};
          default: act = {31'd0, flush_pulse};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [4:0] bank, input int word, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = {bank, 5'(word), 2'b00};
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic push(input int kind, input int idx, input logic [31:0] e, input string tag);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    -> mon_ev;
    #2;
  endtask

  task automatic rd(input logic [4:0] bank, input int word, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = {bank, 5'(word), 2'b00};
    push(0, 0, e, tag);
  endtask

  task automatic setin(input int line, input logic v);
    @(negedge clk);
    irq_in[line] = v;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state
    rd(B_MASK, 0,  32'hFFFF_FFFF, "R13 mask w0");
    rd(B_MASK, 13, 32'h007F_FFFF, "R13 mask w13");
    rd(B_POL, 13,  32'h007F_FFFF, "R13 pol w13");
    rd(B_SENS, 0,  32'h0, "R13 sens w0");
    rd(B_STAT, 0,  32'h0, "R13 status w0");
    rd(B_CTRL, 0,  32'h0, "R13 ctrl");
    // R1 partial last word and out-of-range word
    wr(B_SSET, 13, 32'hFFFF_FFFF);
    rd(B_SENS, 13, 32'h007F_FFFF, "R1 sens w13 upper bits ignored");
    wr(B_SCLR, 13, 32'hFFFF_FFFF);
    rd(B_SENS, 13, 32'h0, "R1 sens w13 cleared");
    rd(B_MASK, 14, 32'h0, "R1 word beyond range");
    // R3 alias semantics, R2 bank placement
    wr(B_CTRL, 0, 32'h1);
    wr(B_MCLR, 0, 32'h20);
    rd(B_MASK, 0, 32'hFFFF_FFDF, "R3 mask clear single bit");
    wr(B_MSET, 0, 32'h0);
    rd(B_MASK, 0, 32'hFFFF_FFDF, "R3 zero write no effect");
    // R6 rising edge, R2 pending output
    setin(5, 1'b1); waitc(4);
    rd(B_STAT, 0, 32'h20, "R6 rising edge captured");
    push(1, 5, 32'h1, "R2 pend_out line 5");
    setin(5, 1'b0); waitc(4);
    rd(B_STAT, 0, 32'h20, "R10 status held after input drops");
    // R5 masked line
    setin(6, 1'b1); waitc(4);
    rd(B_STAT, 0, 32'h20, "R5 masked line not captured");
    setin(6, 1'b0);
    // R4 acknowledge
    wr(B_ACK, 0, 32'h20);
    rd(B_STAT, 0, 32'h0, "R4 ack clears status");
    // R6 falling edge
    wr(B_PCLR, 0, 32'h80);
    rd(B_POL, 0, 32'hFFFF_FF7F, "R3 pol clear single bit");
    wr(B_MCLR, 0, 32'h80);
    setin(7, 1'b1); waitc(4);
    rd(B_STAT, 0, 32'h0, "R6 rising ignored for falling polarity");
    setin(7, 1'b0); waitc(4);
    rd(B_STAT, 0, 32'h80, "R6 falling edge captured");
    wr(B_ACK, 0, 32'h80);
    // R7 level mode
    wr(B_SSET, 0, 32'h100);
    rd(B_SENS, 0, 32'h100, "R7 sens set");
    wr(B_MCLR, 0, 32'h100);
    setin(8, 1'b1); waitc(4);
    rd(B_STAT, 0, 32'h100, "R7 level captured");
    wr(B_ACK, 0, 32'h100); waitc(1);
    rd(B_STAT, 0, 32'h100, "R7 level re-captured after ack");
    // R8 edge-only override
    wr(B_CTRL, 0, 32'h3);
    wr(B_ACK, 0, 32'h100); waitc(4);
    rd(B_STAT, 0, 32'h0, "R8 held level not captured");
    setin(8, 1'b0); waitc(4);
    setin(8, 1'b1); waitc(4);
    rd(B_STAT, 0, 32'h100, "R8 edge captured in edge-only");
    setin(8, 1'b0); waitc(4);
    wr(B_ACK, 0, 32'h100);
    // R9 disable
    wr(B_CTRL, 0, 32'h0);
    setin(5, 1'b1); waitc(4);
    rd(B_STAT, 0, 32'h0, "R9 no capture while disabled");
    setin(5, 1'b0); waitc(4);
    // R1 last line
    wr(B_CTRL, 0, 32'h1);
    wr(B_MCLR, 13, 32'hFFFF_FFFF);
    rd(B_MASK, 13, 32'h0, "R1 mask w13 cleared");
    setin(438, 1'b1); waitc(4);
    rd(B_STAT, 13, 32'h0040_0000, "R1 line 438 at word 13 bit 22");
    push(1, 438, 32'h1, "R1 pend_out line 438");
    // R11 flush
    wr(B_CTRL, 0, 32'h5);
    push(2, 0, 32'h1, "R11 flush pulse high");
    @(negedge clk);
    push(2, 0, 32'h0, "R11 flush pulse low after one cycle");
    rd(B_CTRL, 0, 32'h1, "R11 flush bit self-cleared");
    // R12 software reset
    wr(B_CTRL, 0, 32'h0010_0001); waitc(2);
    rd(B_CTRL, 0, 32'h0, "R12 ctrl cleared");
    rd(B_STAT, 13, 32'h0, "R12 status cleared");
    rd(B_MASK, 0, 32'hFFFF_FFFF, "R12 mask w0 set");
    rd(B_MASK, 13, 32'h007F_FFFF, "R12 mask w13 set");
    rd(B_SENS, 0, 32'h100, "R12 sens kept");
    rd(B_POL, 0, 32'hFFFF_FF7F, "R12 pol kept");
    waitc(2);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule